// File: doc/BRIEF.md
# Character LCD Write Driver

This block drives a two-line, sixteen-column character display that has its own controller and a parallel bus: eight data lines plus a select line, a direction line and an enable strobe. After reset it waits for the panel's power-up time. It then brings the panel up by sending a fixed series of instructions. After that it accepts one instruction or one character at a time through a valid/ready handshake.

Every byte goes out either whole, with one enable pulse, or as two nibbles on the upper four data lines, each with its own pulse. The width is chosen by an input pin that is sampled when the power-up wait ends. The line count, glyph height and the display, cursor and blink flags are sampled at the same moment. Every timing value is a cycle-count parameter. The driver never reads from the panel. It waits a fixed time after each command instead of polling the busy flag.

Top module: `charlcd_drv`

## Requirements
- R1: `lcd_rw` is 0 at all times; every transfer is a write.
- R2: `lcd_rs` is 0 while an instruction is on the bus (all start-up commands, and requests with `req_is_data`=0) and 1 while a character is on the bus (`req_is_data`=1).
- R3: From reset until `PWRUP_CYC` cycles after reset is released, `lcd_en`, `lcd_rs` and `lcd_db` stay 0.
- R4: The start-up commands go out in this order: the function-set byte 0x20 | wide<<4 | two_lines<<3 | tall_font<<2, then the display-control byte 0x08 | disp_on<<2 | cursor_on<<1 | blink_on, then clear (0x01).
- R5: In 8-bit mode each byte is sent with a single enable pulse, with the whole byte on `lcd_db[7:0]`.
- R6: In 4-bit mode each byte is sent with two pulses. The upper nibble goes first, then the lower, both on `lcd_db[7:4]`, and `lcd_db[3:0]`=0 during each pulse.
- R7: Each enable pulse is high for exactly `EN_CYC` cycles. `lcd_db` and `lcd_rs` are already valid one cycle before the pulse rises and stay unchanged while it is high.
- R8: After the last pulse of a byte, the enable line stays low for at least `EN_CYC+CMD_WAIT+1` cycles, or `EN_CYC+CLR_WAIT+1` after an instruction 0x01. Between the two nibbles of a byte it stays low for at least `EN_CYC+1` cycles.
- R9: `req_ready` is 0 from reset until the clear wait of start-up ends, and from each accepted request until that byte's wait ends. A request is taken only in a cycle where both `req_valid` and `req_ready` are 1.
- R10: In 4-bit mode, start-up first sends a single pulse carrying 0x2 on `lcd_db[7:4]`, followed by the command wait, before the function set. Width and panel options are taken only at the end of the power-up wait; later changes on those pins have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects 8-bit transfers, 0 selects 4-bit |
| cfg_two_lines | input | 1 | Two display lines |
| cfg_tall_font | input | 1 | 5×10 glyphs |
| cfg_disp_on | input | 1 | Display enabled |
| cfg_cursor_on | input | 1 | Cursor shown |
| cfg_blink_on | input | 1 | Cursor blinks |
| req_valid | input | 1 | Request present |
| req_is_data | input | 1 | 1 = character, 0 = instruction |
| req_byte | input | 8 | Byte to send |
| req_ready | output | 1 | Driver can take a request |
| lcd_rs | output | 1 | Register select |
| lcd_rw | output | 1 | Read/write, always write |
| lcd_en | output | 1 | Enable strobe |
| lcd_db | output | 8 | Data bus |

## Verification
The start-up sequencer and the request handshake can act in the same cycle. Immediately after the second reset, the bench raises `req_valid` and holds it through the whole power-up and start-up phase, so the request is pending in the exact cycle the clear wait ends and `req_ready` rises. The scoreboard judges the result. The request's first pulse must come only after the clear pulse, and only after at least the clear wait. No extra pulse may appear, and every start-up command must arrive intact and in order before it.

// File: rtl/charlcd_drv.sv
module charlcd_drv #(
  parameter int PWRUP_CYC = 4_000_000,
  parameter int EN_CYC    = 300,
  parameter int CMD_WAIT  = 12_500,
  parameter int CLR_WAIT  = 500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wide,
  input  logic       cfg_two_lines,
  input  logic       cfg_tall_font,
  input  logic       cfg_disp_on,
  input  logic       cfg_cursor_on,
  input  logic       cfg_blink_on,
  input  logic       req_valid,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic       req_ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_db
);
  localparam int M1   = (PWRUP_CYC > EN_CYC) ? PWRUP_CYC : EN_CYC;
  localparam int M2   = (CMD_WAIT > CLR_WAIT) ? CMD_WAIT : CLR_WAIT;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] C_PWR = CW'(PWRUP_CYC - 1);
  localparam logic [CW-1:0] C_EN  = CW'(EN_CYC - 1);
  localparam logic [CW-1:0] C_CMD = CW'(CMD_WAIT - 1);
  localparam logic [CW-1:0] C_CLR = CW'(CLR_WAIT - 1);
  localparam logic [2:0] STEP_USER = 3'd4;

  typedef enum logic [1:0] {S_PWR, S_XFER, S_IDLE} st_t;
  typedef enum logic [1:0] {P_SU, P_HI, P_LO, P_WT} ph_t;

  st_t           st;
  ph_t           ph;
  logic [CW-1:0] cnt;
  logic [2:0]    step;
  logic          nib_hi;
  logic [7:0]    cur_byte;
  logic          cur_rs;
  logic          m8_q, lines_q, tall_q, don_q, cur_q, blk_q;
  logic [7:0]    init_byte, tx_byte;
  logic          tx_rs, active, single, last_nib;

  always_comb begin
    case (step)
      3'd0:    init_byte = 8'h20;
      3'd1:    init_byte = {3'b001, m8_q, lines_q, tall_q, 2'b00};
      3'd2:    init_byte = {5'b00001, don_q, cur_q, blk_q};
      default: init_byte = 8'h01;
    endcase
  end

  assign tx_byte  = (step < STEP_USER) ? init_byte : cur_byte;
  assign tx_rs    = (step < STEP_USER) ? 1'b0 : cur_rs;
  assign single   = (step == 3'd0);
  assign last_nib = m8_q || !nib_hi || single;
  assign active   = (st == S_XFER) && (ph != P_WT);

  assign req_ready = (st == S_IDLE);
  assign lcd_rw    = 1'b0;
  assign lcd_en    = (st == S_XFER) && (ph == P_HI);
  assign lcd_rs    = active && tx_rs;
  assign lcd_db    = !active ? 8'h00 :
                     m8_q    ? tx_byte :
                     nib_hi  ? {tx_byte[7:4], 4'h0} : {tx_byte[3:0], 4'h0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PWR; ph <= P_SU; cnt <= C_PWR; step <= 3'd0; nib_hi <= 1'b1;
      cur_byte <= 8'h00; cur_rs <= 1'b0;
      m8_q <= 1'b0; lines_q <= 1'b0; tall_q <= 1'b0;
      don_q <= 1'b0; cur_q <= 1'b0; blk_q <= 1'b0;
    end else begin
      case (st)
        S_PWR: begin
          m8_q <= cfg_wide; lines_q <= cfg_two_lines; tall_q <= cfg_tall_font;
          don_q <= cfg_disp_on; cur_q <= cfg_cursor_on; blk_q <= cfg_blink_on;
          if (cnt == '0) begin
            st <= S_XFER; ph <= P_SU; nib_hi <= 1'b1;
            step <= cfg_wide ? 3'd1 : 3'd0;
          end else cnt <= cnt - 1'b1;
        end
        S_XFER: begin
          case (ph)
            P_SU: begin ph <= P_HI; cnt <= C_EN; end
            P_HI: begin
              if (cnt == '0) begin ph <= P_LO; cnt <= C_EN; end
              else cnt <= cnt - 1'b1;
            end
            P_LO: begin
              if (cnt != '0) cnt <= cnt - 1'b1;
              else if (!last_nib) begin nib_hi <= 1'b0; ph <= P_SU; end
              else begin
                ph  <= P_WT;
                cnt <= (tx_byte == 8'h01 && !tx_rs) ? C_CLR : C_CMD;
              end
            end
            default: begin
              if (cnt != '0) cnt <= cnt - 1'b1;
              else begin
                nib_hi <= 1'b1; ph <= P_SU;
                if (step < 3'd3) step <= step + 3'd1;
                else begin
                  step <= STEP_USER; st <= S_IDLE;
                end
              end
            end
          endcase
        end
        default: begin
          if (req_valid) begin
            st <= S_XFER; ph <= P_SU; nib_hi <= 1'b1;
            cur_byte <= req_byte; cur_rs <= req_is_data;
          end
        end
      endcase
    end
  end

  AST_EN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> !req_ready); // R9
  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R9
  AST_DB_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs)); // R7
  AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en && $past(lcd_en) |-> $stable(lcd_db) && $stable(lcd_rs)); // R7
  AST_NIBBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en && !m8_q |-> lcd_db[3:0] == 4'h0); // R6
  AST_QUIET_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PWR |-> !lcd_en && !lcd_rs && lcd_db == 8'h00); // R3
endmodule

// File: tb/charlcd_drv_tb.sv
module charlcd_drv_tb;
  localparam int PWR = 40, EN = 3, CMD = 10, CLR = 30;

  logic clk = 0, rst_n = 0;
  logic cfg_wide, cfg_two_lines, cfg_tall_font, cfg_disp_on, cfg_cursor_on, cfg_blink_on;
  logic req_valid = 0, req_is_data = 0;
  logic [7:0] req_byte = 0;
  logic req_ready, lcd_rs, lcd_rw, lcd_en;
  logic [7:0] lcd_db;

  int errors = 0, checks = 0;
  logic [24:0] expq[$];

  always #2 clk = ~clk;

  charlcd_drv #(.PWRUP_CYC(PWR), .EN_CYC(EN), .CMD_WAIT(CMD), .CLR_WAIT(CLR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_two_lines(cfg_two_lines),
    .cfg_tall_font(cfg_tall_font), .cfg_disp_on(cfg_disp_on), .cfg_cursor_on(cfg_cursor_on),
    .cfg_blink_on(cfg_blink_on), .req_valid(req_valid), .req_is_data(req_is_data),
    .req_byte(req_byte), .req_ready(req_ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_en(lcd_en), .lcd_db(lcd_db));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic push_byte(input bit rs, input logic [7:0] b, input bit m8, input int gap);
    if (m8) expq.push_back({16'(gap), rs, b});
    else begin
      expq.push_back({16'(gap), rs, b[7:4], 4'h0});
      expq.push_back({16'(EN + 1), rs, b[3:0], 4'h0});
    end
  endtask

  task automatic send(input bit d, input logic [7:0] b, input bit m8, input int gap);
    push_byte(d, b, m8, gap);
    @(negedge clk);
    req_valid = 1; req_is_data = d; req_byte = b;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  // Scoreboard monitor
  int  lowcnt = 0, highcnt = 0;
  bit  prev_en = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      lowcnt = 0; highcnt = 0; prev_en = 0;
    end else begin
      check(lcd_rw == 1'b0, "R1 rw low", lcd_rw, 0);
      if (lcd_en && !prev_en) begin
        if (expq.size() == 0) check(0, "R9 unexpected pulse", lcd_db, 0);
        else begin
          logic [24:0] e;
          e = expq.pop_front();
          check(lcd_rs == e[8], "R2 rs", lcd_rs, e[8]);
          check(lcd_db == e[7:0], "R4 R5 R6 R10 bus byte", lcd_db, e[7:0]);
          check(lowcnt >= int'(e[24:9]), "R3 R8 low gap", lowcnt, e[24:9]);
        end
        highcnt = 1;
      end else if (lcd_en) highcnt++;
      else if (prev_en) begin
        check(highcnt == EN, "R7 pulse width", highcnt, EN);
        lowcnt = 1;
      end else lowcnt++;
      prev_en = lcd_en;
    end
  end

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    // Phase A: 8-bit, two lines, 5x8, display+cursor on, no blink
    cfg_wide = 1; cfg_two_lines = 1; cfg_tall_font = 0;
    cfg_disp_on = 1; cfg_cursor_on = 1; cfg_blink_on = 0;
    repeat (5) @(negedge clk);
    check(lcd_en == 0 && lcd_rs == 0 && lcd_db == 0, "R3 reset outputs", {lcd_en, lcd_rs, lcd_db}, 0);
    check(req_ready == 0, "R9 ready in reset", req_ready, 0);
    push_byte(0, 8'h38, 1, PWR);              // R4 function set
    push_byte(0, 8'h0E, 1, EN + CMD + 1);     // R4 display control
    push_byte(0, 8'h01, 1, EN + CMD + 1);     // R4 clear
    rst_n = 1;
    repeat (PWR / 2) @(negedge clk);
    check(req_ready == 0, "R9 ready during power-up", req_ready, 0);
    send(1, 8'h41, 1, EN + CLR + 1);          // R2 R5 character
    send(0, 8'h80, 1, EN + CMD + 1);          // R2 instruction
    cfg_wide = 0;                             // R10 late change ignored
    send(1, 8'h55, 1, EN + CMD + 1);
    drain();
    check(req_ready == 1, "R9 ready after phase A", req_ready, 1);

    // Phase B: 4-bit, one line, 5x10, display on, cursor off, blink on
    @(negedge clk);
    rst_n = 0;
    cfg_wide = 0; cfg_two_lines = 0; cfg_tall_font = 1;
    cfg_disp_on = 1; cfg_cursor_on = 0; cfg_blink_on = 1;
    repeat (3) @(negedge clk);
    check(lcd_en == 0 && req_ready == 0, "R3 second reset", {lcd_en, req_ready}, 0);
    expq.push_back({16'(PWR), 1'b0, 8'h20}); // R10 lone nibble
    push_byte(0, 8'h24, 0, EN + CMD + 1);     // R4 R6 function set
    push_byte(0, 8'h0D, 0, EN + CMD + 1);     // R4 display control
    push_byte(0, 8'h01, 0, EN + CMD + 1);     // R4 clear
    rst_n = 1;
    // R9: request already pending when start-up ends
    send(1, 8'h7E, 0, EN + CLR + 1);
    send(0, 8'h01, 0, EN + CMD + 1);          // R8 user clear
    send(1, 8'h33, 0, EN + CLR + 1);          // R8 long wait after clear
    drain();
    check(req_ready == 1, "R9 ready after phase B", req_ready, 1);
    check(expq.size() == 0, "R5 R6 all pulses seen", expq.size(), 0);
    finish_run();
  end
endmodule